// File: doc/BRIEF.md
# Write Strobe Legality Checker

This block watches the write address and write data channels of an AXI4 port with a 32-bit data bus. It never drives a handshake signal and never holds up the bus. Each accepted address handshake of an incrementing burst stores a record in a small in-order queue. The record holds the start address, the beat count field and the transfer size. The write data beats then consume these records one burst at a time. For every beat the block works out which byte lanes that beat may enable. It takes the beat's own address and the transfer size, and it checks the sampled strobe against them.

An unaligned first beat may only enable lanes from its byte offset up to the end of its size-aligned container. Every later beat starts on a size boundary and may enable any lane of its container. Any pattern of enabled lanes inside the permitted set is accepted, even a sparse one. The pattern may also change from beat to beat. A strobe bit outside the permitted set raises a one-cycle error pulse, which reports the beat index and the offending strobe. A second one-cycle error reports a burst-end marker that does not match the length given with the address.

Strobe bit i governs byte lane i, which holds the byte whose address has low bits equal to i. A strobe written as a binary value such as 1110 lists lane 3 first and lane 0 last.

Top module: `wstrb_monitor`

## Requirements
- R1: While reset is applied and after it is released, with no data beat accepted since, strb_err and last_err are low and err_beat and err_strb are zero.
- R2: For a full-word burst (size code 2) whose start address has low bits 00, any strobe value is accepted on the first beat. This includes 1110, the sparse 1011, and 1111.
- R3: For a full-word burst whose start address has a nonzero byte offset, the first beat may enable only lanes at or above that offset. At offset 1, strobe 0111 is an error and 1110 is accepted. At offset 3, 1000 is accepted and 0100 is an error.
- R4: After the first beat, each beat's address is the previous beat's address aligned down to the size and then advanced by one transfer. All lanes of that container are permitted, and the strobe may differ on every beat. The sequence 1011, 0010, 0011 from address 0 at full-word size is accepted.
- R5: For narrow sizes (size code 0 is one byte, code 1 is two bytes), a beat may enable only the lanes of its own size-aligned container, starting no lower than the beat's address offset. A byte burst from offset 1 permits lane 1, then lane 2, then lane 3, then lane 0. A halfword burst from offset 2 permits lanes 2 and 3, then lanes 0 and 1.
- R6: An illegal strobe sets strb_err high for exactly the one cycle after the data handshake. In that same cycle err_beat holds the zero-based beat index within the burst and err_strb holds the sampled strobe. Both hold their values until the next strobe error.
- R7: Strobe and last-beat inputs have no effect in any cycle where w_valid and w_ready are not both high. Such a cycle raises no error and does not advance the beat.
- R8: A beat with strobe 0000 is always accepted.
- R9: last_err pulses high for one cycle after a data handshake in either of two cases. The first is w_last high on a beat whose index differs from the length field. The second is w_last low on the beat whose index equals it. A burst ends, and its record is released, at the handshake carrying w_last.
- R10: Up to DEPTH address records may be outstanding. Data beats are checked against them in the order the addresses were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| aw_valid | input | 1 | Write address valid observed on the bus |
| aw_ready | input | 1 | Write address ready observed on the bus |
| aw_addr | input | ADDR_W | Burst start address |
| aw_len | input | 8 | Beats in the burst minus one |
| aw_size | input | 3 | Transfer size code, bytes = 2^code |
| w_valid | input | 1 | Write data valid observed on the bus |
| w_ready | input | 1 | Write data ready observed on the bus |
| w_strb | input | DATA_W/8 | Byte lane strobes of the beat |
| w_last | input | 1 | Final beat marker of the burst |
| strb_err | output | 1 | One-cycle pulse for a strobe outside the permitted lanes |
| err_beat | output | 8 | Beat index of the latest strobe error |
| err_strb | output | DATA_W/8 | Strobe value of the latest strobe error |
| last_err | output | 1 | One-cycle pulse for a misplaced or missing final-beat marker |

## Verification
The assertions take four things for granted about the bus. Every accepted address carries a size code no larger than the bus width allows. No more than DEPTH addresses are outstanding. A data beat is never accepted before the address record of its burst has been stored, which takes one cycle. The bench keeps within these rules by construction. It issues each address handshake on its own cycle before any data of that burst, draws sizes only from the byte, halfword and word codes, and queues at most four bursts ahead of their data. Inside those limits the bench varies everything else freely: start offsets, lengths, stalls, illegal strobes and wrong burst-end markers.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned SIZE_W = 3;

  typedef logic [LEN_W-1:0]  beat_idx_t;
  typedef logic [SIZE_W-1:0] xfer_size_t;
endpackage

// File: rtl/wsm_rst_sync.sv
module wsm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wsm_rec_fifo.sv
module wsm_rec_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;
  logic             do_push;
  logic             do_pop;
  logic [WIDTH-1:0] ent_rd [DEPTH];

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  always_comb begin
    do_push  = push_i && !full;
    do_pop   = pop_i && !empty_o;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [WIDTH-1:0] ent_q;
    logic             ent_we;
    assign ent_we = do_push && (wr_ptr_q == PTR_W'(e));
    always_ff @(posedge clk_i) begin
      if (ent_we) begin
        ent_q <= din_i;
      end
    end
    assign ent_rd[e] = ent_q;
  end

  assign dout_o = ent_rd[rd_ptr_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full); // R10

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R10
endmodule

// File: rtl/wsm_lane_mask.sv
module wsm_lane_mask #(
  parameter int unsigned STRB_W = 4,
  parameter int unsigned OFF_W  = 2
) (
  input  logic [OFF_W-1:0]          off_i,
  input  wsm_pkg::xfer_size_t       size_i,
  output logic [STRB_W-1:0]         mask_o
);
  logic [OFF_W:0] span;
  logic [OFF_W:0] base;
  logic [OFF_W:0] top;

  always_comb begin
    if (size_i >= wsm_pkg::SIZE_W'(OFF_W)) begin
      span = (OFF_W+1)'(STRB_W);
    end else begin
      span = (OFF_W+1)'(1) << size_i;
    end
    base = {1'b0, off_i} & ~(span - 1'b1);
    top  = base + span;
  end

  for (genvar l = 0; l < STRB_W; l++) begin : g_lane
    assign mask_o[l] = ({1'b0, off_i} <= (OFF_W+1)'(l)) && ((OFF_W+1)'(l) < top);
  end
endmodule

// File: rtl/wsm_beat_track.sv
module wsm_beat_track #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hs_i,
  input  logic                  last_i,
  input  logic [ADDR_W-1:0]     head_addr_i,
  input  wsm_pkg::xfer_size_t   head_size_i,
  output logic [ADDR_W-1:0]     cur_addr_o,
  output wsm_pkg::beat_idx_t    beat_o
);
  logic                first_q, first_d;
  wsm_pkg::beat_idx_t  beat_q, beat_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   step;
  logic [ADDR_W-1:0]   aligned;
  logic [ADDR_W-1:0]   cur_addr;

  always_comb begin
    cur_addr = first_q ? head_addr_i : addr_q;
    step     = ADDR_W'(1) << head_size_i;
    aligned  = cur_addr & ~(step - 1'b1);
    first_d  = first_q;
    beat_d   = beat_q;
    addr_d   = addr_q;
    if (last_i) begin
      first_d = 1'b1;
      beat_d  = '0;
    end else begin
      first_d = 1'b0;
      beat_d  = beat_q + 1'b1;
      addr_d  = aligned + step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      beat_q  <= '0;
      addr_q  <= '0;
    end else if (hs_i) begin
      first_q <= first_d;
      beat_q  <= beat_d;
      addr_q  <= addr_d;
    end
  end

  assign cur_addr_o = cur_addr;
  assign beat_o     = beat_q;

  AST_LATER_BEAT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_i && !first_q) |-> ((addr_q & (step - 1'b1)) == '0)); // R4

  AST_FIRST_BEAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (beat_q == '0)); // R9
endmodule

// File: rtl/wstrb_monitor.sv
module wstrb_monitor #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  aw_valid,
  input  logic                  aw_ready,
  input  logic [ADDR_W-1:0]     aw_addr,
  input  logic [7:0]            aw_len,
  input  logic [2:0]            aw_size,
  input  logic                  w_valid,
  input  logic                  w_ready,
  input  logic [DATA_W/8-1:0]   w_strb,
  input  logic                  w_last,
  output logic                  strb_err,
  output logic [7:0]            err_beat,
  output logic [DATA_W/8-1:0]   err_strb,
  output logic                  last_err
);
  import wsm_pkg::*;

  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(STRB_W);
  localparam int unsigned REC_W  = ADDR_W + LEN_W + SIZE_W;

  logic              rst_n_s;
  logic              aw_hs;
  logic              w_hs;
  logic              w_chk;
  logic [REC_W-1:0]  rec_in;
  logic [REC_W-1:0]  rec_head;
  logic              rec_empty;
  logic [ADDR_W-1:0] head_addr;
  beat_idx_t         head_len;
  xfer_size_t        head_size;
  logic [ADDR_W-1:0] cur_addr;
  beat_idx_t         beat;
  logic [STRB_W-1:0] lane_ok;
  logic              strb_bad;
  logic              last_bad;

  logic              strb_err_q, strb_err_d;
  logic              last_err_q, last_err_d;
  logic              cap_en;
  beat_idx_t         err_beat_q, err_beat_d;
  logic [STRB_W-1:0] err_strb_q, err_strb_d;

  wsm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  assign aw_hs  = aw_valid && aw_ready;
  assign w_hs   = w_valid && w_ready;
  assign w_chk  = w_hs && !rec_empty;
  assign rec_in = {aw_addr, aw_len, aw_size};

  wsm_rec_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) i_rec_fifo (
    .clk_i   (clk),
    .rst_ni  (rst_n_s),
    .push_i  (aw_hs),
    .din_i   (rec_in),
    .pop_i   (w_chk && w_last),
    .dout_o  (rec_head),
    .empty_o (rec_empty)
  );

  assign head_addr = rec_head[REC_W-1 -: ADDR_W];
  assign head_len  = rec_head[SIZE_W +: LEN_W];
  assign head_size = rec_head[SIZE_W-1:0];

  wsm_beat_track #(.ADDR_W(ADDR_W)) i_beat_track (
    .clk_i       (clk),
    .rst_ni      (rst_n_s),
    .hs_i        (w_chk),
    .last_i      (w_last),
    .head_addr_i (head_addr),
    .head_size_i (head_size),
    .cur_addr_o  (cur_addr),
    .beat_o      (beat)
  );

  wsm_lane_mask #(.STRB_W(STRB_W), .OFF_W(OFF_W)) i_lane_mask (
    .off_i  (cur_addr[OFF_W-1:0]),
    .size_i (head_size),
    .mask_o (lane_ok)
  );

  always_comb begin
    strb_bad   = |(w_strb & ~lane_ok);
    last_bad   = w_last != (beat == head_len);
    strb_err_d = w_chk && strb_bad;
    last_err_d = w_chk && last_bad;
    cap_en     = w_chk && strb_bad;
    err_beat_d = beat;
    err_strb_d = w_strb;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      strb_err_q <= 1'b0;
      last_err_q <= 1'b0;
    end else begin
      strb_err_q <= strb_err_d;
      last_err_q <= last_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_beat_q <= '0;
      err_strb_q <= '0;
    end else if (cap_en) begin
      err_beat_q <= err_beat_d;
      err_strb_q <= err_strb_d;
    end
  end

  assign strb_err = strb_err_q;
  assign last_err = last_err_q;
  assign err_beat = err_beat_q;
  assign err_strb = err_strb_q;

  AST_W_HAS_RECORD: assert property (@(posedge clk) disable iff (!rst_n_s)
    w_hs |-> !rec_empty); // R10

  AST_SIZE_FITS_BUS: assert property (@(posedge clk) disable iff (!rst_n_s)
    aw_hs |-> (aw_size <= SIZE_W'(OFF_W))); // R5

  AST_OFFSET_LANE_OPEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    w_chk |-> lane_ok[cur_addr[OFF_W-1:0]]); // R3

  AST_STRB_ERR_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n_s)
    strb_err |-> $past(w_valid && w_ready)); // R6

  AST_ERR_STRB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    strb_err |-> (err_strb != '0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(w_valid && w_ready) |=> (!strb_err && !last_err)); // R7

  AST_ZERO_STRB_OK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (w_valid && w_ready && (w_strb == '0)) |=> !strb_err); // R8

  AST_LAST_ERR_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n_s)
    last_err |-> $past(w_valid && w_ready)); // R9
endmodule

// File: tb/test_wstrb_monitor.sv
module test_wstrb_monitor;
  logic        clk;
  logic        rst_n;
  logic        aw_valid, aw_ready;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len;
  logic [2:0]  aw_size;
  logic        w_valid, w_ready;
  logic [3:0]  w_strb;
  logic        w_last;
  logic        strb_err;
  logic [7:0]  err_beat;
  logic [3:0]  err_strb;
  logic        last_err;

  int n_chk;
  int n_fail;
  bit done;

  int m_off  [16];
  int m_len  [16];
  int m_size [16];
  int m_wr, m_rd, m_beat, m_cur;
  bit m_first;
  int exp_beat, exp_strb;

  wstrb_monitor i_wstrb_monitor (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_addr  (aw_addr),
    .aw_len   (aw_len),
    .aw_size  (aw_size),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_strb   (w_strb),
    .w_last   (w_last),
    .strb_err (strb_err),
    .err_beat (err_beat),
    .err_strb (err_strb),
    .last_err (last_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] exp_mask(int off, int size);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) begin
      m[i] = (i >= off) && ((i >> size) == (off >> size));
    end
    return m;
  endfunction

  function automatic int exp_next(int off, int size);
    return (((off >> size) + 1) << size) % 4;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic aw_put(int addr, int len, int size);
    aw_valid = 1'b1;
    aw_ready = 1'b1;
    aw_addr  = 32'(addr);
    aw_len   = 8'(len);
    aw_size  = 3'(size);
    @(negedge clk);
    aw_valid = 1'b0;
    aw_ready = 1'b0;
    m_off[m_wr]  = addr % 4;
    m_len[m_wr]  = len;
    m_size[m_wr] = size;
    m_wr = (m_wr + 1) % 16;
  endtask

  task automatic w_put(logic [3:0] strb, bit last, bit vld, bit rdy, string tag);
    int  off;
    int  sz;
    bit  es;
    bit  el;
    es = 1'b0;
    el = 1'b0;
    w_valid = vld;
    w_ready = rdy;
    w_strb  = strb;
    w_last  = last;
    if (vld && rdy) begin
      off = m_first ? m_off[m_rd] : m_cur;
      sz  = m_size[m_rd];
      es  = |(strb & ~exp_mask(off, sz));
      el  = (last != (m_beat == m_len[m_rd]));
      if (es) begin
        exp_beat = m_beat;
        exp_strb = int'(strb);
      end
      if (last) begin
        m_first = 1'b1;
        m_beat  = 0;
        m_rd    = (m_rd + 1) % 16;
      end else begin
        m_first = 1'b0;
        m_beat  = (m_beat + 1) % 256;
        m_cur   = exp_next(off, sz);
      end
    end
    @(negedge clk);
    chk(tag, "strb_err", int'(strb_err), int'(es));
    chk(tag, "last_err", int'(last_err), int'(el));
    chk(tag, "err_beat", int'(err_beat), exp_beat);
    chk(tag, "err_strb", int'(err_strb), exp_strb);
    w_valid = 1'b0;
    w_ready = 1'b0;
  endtask

  task automatic idle_chk(string tag);
    @(negedge clk);
    chk(tag, "strb_err idle", int'(strb_err), 0);
    chk(tag, "last_err idle", int'(last_err), 0);
    chk(tag, "err_strb held", int'(err_strb), exp_strb);
    chk(tag, "err_beat held", int'(err_beat), exp_beat);
  endtask

  task automatic run_random();
    int a, sz, ln, nb, r, loff;
    logic [3:0] s;
    for (int b = 0; b < 400; b++) begin
      a  = $urandom_range(0, 3);
      sz = $urandom_range(0, 2);
      ln = $urandom_range(0, 6);
      r  = $urandom_range(0, 9);
      nb = ln + 1;
      if (r == 0) nb = ln + 2;
      else if (r == 1 && ln > 0) nb = ln;
      aw_put(a + 64 * b, ln, sz);
      loff = a;
      for (int k = 0; k < nb; k++) begin
        s = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 1) == 1) s = s & exp_mask(loff, sz);
        if ($urandom_range(0, 7) == 0) w_put(~s, 1'b1, 1'b1, 1'b0, "R7");
        w_put(s, k == nb - 1, 1'b1, 1'b1, "R5");
        loff = exp_next(loff, sz);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the bench finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    m_wr = 0; m_rd = 0; m_beat = 0; m_cur = 0; m_first = 1'b1;
    exp_beat = 0; exp_strb = 0;
    rst_n = 1'b0;
    aw_valid = 1'b0; aw_ready = 1'b0; aw_addr = '0; aw_len = '0; aw_size = '0;
    w_valid = 1'b0; w_ready = 1'b0; w_strb = '0; w_last = 1'b0;
    void'($urandom(32'd51966));
    repeat (3) @(negedge clk);
    chk("R1", "strb_err in reset", int'(strb_err), 0);
    chk("R1", "last_err in reset", int'(last_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "strb_err", int'(strb_err), 0);
    chk("R1", "last_err", int'(last_err), 0);
    chk("R1", "err_beat", int'(err_beat), 0);
    chk("R1", "err_strb", int'(err_strb), 0);

    // R2: aligned word start, any pattern
    aw_put(0, 0, 2);  w_put(4'b1110, 1, 1, 1, "R2");
    aw_put(0, 0, 2);  w_put(4'b1011, 1, 1, 1, "R2");
    aw_put(16, 0, 2); w_put(4'b1111, 1, 1, 1, "R2");

    // R3: unaligned first beat
    aw_put(1, 0, 2);  w_put(4'b0111, 1, 1, 1, "R3");
    idle_chk("R6");
    aw_put(1, 0, 2);  w_put(4'b1110, 1, 1, 1, "R3");
    aw_put(3, 1, 2);  w_put(4'b1000, 0, 1, 1, "R3"); w_put(4'b1111, 1, 1, 1, "R4");
    aw_put(3, 0, 2);  w_put(4'b0100, 1, 1, 1, "R3");

    // R4: later beats full container, changing patterns
    aw_put(0, 2, 2);
    w_put(4'b1011, 0, 1, 1, "R4"); w_put(4'b0010, 0, 1, 1, "R4"); w_put(4'b0011, 1, 1, 1, "R4");
    aw_put(2, 2, 2);
    w_put(4'b1100, 0, 1, 1, "R4"); w_put(4'b0001, 0, 1, 1, "R4"); w_put(4'b1111, 1, 1, 1, "R4");

    // R5: narrow sizes
    aw_put(1, 3, 0);
    w_put(4'b0010, 0, 1, 1, "R5"); w_put(4'b0100, 0, 1, 1, "R5");
    w_put(4'b1000, 0, 1, 1, "R5"); w_put(4'b0001, 1, 1, 1, "R5");
    aw_put(1, 1, 0);  w_put(4'b0100, 0, 1, 1, "R5"); w_put(4'b0100, 1, 1, 1, "R5");
    aw_put(2, 1, 1);  w_put(4'b1100, 0, 1, 1, "R5"); w_put(4'b0011, 1, 1, 1, "R5");
    aw_put(1, 0, 1);  w_put(4'b0010, 1, 1, 1, "R5");
    aw_put(1, 0, 1);  w_put(4'b0100, 1, 1, 1, "R5");

    // R6: error on a later beat reports its index
    aw_put(0, 3, 0);
    w_put(4'b0001, 0, 1, 1, "R6"); w_put(4'b0010, 0, 1, 1, "R6");
    w_put(4'b1000, 0, 1, 1, "R6"); w_put(4'b1000, 1, 1, 1, "R6");
    idle_chk("R6");

    // R7: no handshake, no effect
    aw_put(0, 1, 0);
    w_put(4'b1111, 1, 1, 0, "R7"); w_put(4'b1111, 1, 0, 1, "R7");
    w_put(4'b0001, 0, 1, 1, "R7");
    w_put(4'b1111, 1, 1, 0, "R7");
    w_put(4'b0010, 1, 1, 1, "R7");

    // R8: all-zero strobe
    aw_put(3, 1, 2);  w_put(4'b0000, 0, 1, 1, "R8"); w_put(4'b0000, 1, 1, 1, "R8");

    // R9: early and missing last
    aw_put(0, 2, 2);  w_put(4'b1111, 0, 1, 1, "R9"); w_put(4'b1111, 1, 1, 1, "R9");
    aw_put(0, 1, 2);
    w_put(4'b1111, 0, 1, 1, "R9"); w_put(4'b1111, 0, 1, 1, "R9"); w_put(4'b1111, 1, 1, 1, "R9");
    idle_chk("R9");

    // R10: several outstanding bursts in order
    aw_put(1, 0, 2); aw_put(0, 1, 0); aw_put(2, 0, 1); aw_put(3, 0, 0);
    w_put(4'b0111, 1, 1, 1, "R10");
    w_put(4'b0001, 0, 1, 1, "R10"); w_put(4'b0010, 1, 1, 1, "R10");
    w_put(4'b1100, 1, 1, 1, "R10");
    w_put(4'b1000, 1, 1, 1, "R10");
    aw_put(0, 0, 0); aw_put(2, 0, 2);
    w_put(4'b0010, 1, 1, 1, "R10");
    w_put(4'b0011, 1, 1, 1, "R10");

    run_random();
    idle_chk("R7");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule